// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block takes 16-bit command writes for a hot-plug bus segment and applies them either to one slot or to the whole bus. Each slot holds three 2-bit items: its slot state, its power indicator and its attention indicator. The bus holds one 4-bit speed/mode field. Each command is checked against the slot count, the retention-latch sensors and the programming-interface level. Failures are reported in three error flags.

After a command is accepted, the engine stays busy for a fixed number of cycles. Writes that arrive while it is busy are dropped. When the busy period ends, a command-complete flag is raised. This flag also serves as bit 0 of the interrupt locator, and software clears it with a clear strobe. Software reads the 4-bit status word, waits for the busy bit to drop, and then issues the next command.

Top module: `hpc_cmd_engine`

## Requirements
- R1: After reset, every slot state and both indicators of every slot read 3 (disabled / off), the bus mode reads 0, the status word reads 0 and the complete flag reads 0.
- R2: Codes 0x00-0x3F are slot operations on the slot in word bits 15:8. Code bits 1:0 give the new slot state (1 power only, 2 enabled, 3 disabled), bits 3:2 give the power indicator and bits 5:4 give the attention indicator (1 on, 2 blink, 3 off). A field of 0 leaves its item unchanged.
- R3: A slot operation whose target is at or above NUM_SLOTS sets status bit 2 (invalid command) and changes nothing.
- R4: A slot operation whose state field is 1 or 2, aimed at a slot whose latch input is 1 (open), sets status bit 1 (switch open). No part of that command takes effect.
- R5: Code 0x48 sets every slot state to 1 and code 0x49 sets every slot state to 2, leaving the indicators alone. If any latch is open, the command sets status bit 1 and no slot changes.
- R6: Codes 0x40-0x44 set the bus mode to code minus 0x40, whatever the slot field holds. Codes 0x45-0x47 set status bit 3 (invalid speed/mode) and leave the mode unchanged.
- R7: Codes 0x50-0x5D set the bus mode to code minus 0x50 only when the level-2 input is 1. At level 1, and for codes 0x5E and 0x5F, the command sets status bit 3 and leaves the mode unchanged. The bus mode never exceeds 13.
- R8: Codes 0x4A-0x4F and 0x60-0xFF set status bit 2 and change nothing.
- R9: Status bit 0 (busy) is 1 for exactly BUSY_CYCLES cycles, starting on the cycle after an accepted write. A write issued while busy is ignored.
- R10: Each accepted command replaces status bits 3:1 with its own result, and at most one of those bits is set.
- R11: The complete flag rises on the edge where busy falls and stays set until the clear strobe. If both happen on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 16 | Command word: target slot in 15:8, code in 7:0 |
| prog_lvl2_i | input | 1 | 1 when the programming-interface level is 2 |
| latch_open_i | input | NUM_SLOTS | Retention latch open, one bit per slot |
| cc_clr_i | input | 1 | Clears the command-complete flag |
| status_o | output | 4 | {bad mode, bad command, switch open, busy} |
| cc_pending_o | output | 1 | Command complete, interrupt locator bit 0 |
| bus_mode_o | output | 4 | Bus speed/mode field |
| slot_state_o | output | 2*NUM_SLOTS | Slot state, 2 bits per slot, slot 0 in the low bits |
| pwr_ind_o | output | 2*NUM_SLOTS | Power indicator per slot |
| attn_ind_o | output | 2*NUM_SLOTS | Attention indicator per slot |

## Verification
The assertions check on every cycle that:
- a write during busy leaves all state untouched;
- an accepted write raises busy;
- the error flags stay one-hot-or-zero;
- a switch-open rejection freezes slot state;
- the complete flag is set whenever busy falls;
- the bus mode stays within range.

The exact busy length, the decode of each code range, the no-change fields, the level-dependent handling of the second speed set and the clear strobe can only be shown by the bench. It compares the block's outputs with a model after every command.

// File: rtl/hpc_cmd_pkg.sv
package hpc_cmd_pkg;
  typedef struct packed {
    logic bad_mode;
    logic bad_cmd;
    logic sw_open;
  } hpc_err_t;

  localparam logic [1:0] FLD_KEEP = 2'd0;
  localparam logic [1:0] FLD_OFF  = 2'd3;
  localparam logic [3:0] MODE_MAX = 4'd13;
endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
  import hpc_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [15:0]          word_i,
  input  logic                 lvl2_i,
  input  logic [NUM_SLOTS-1:0] latch_open_i,
  output logic [NUM_SLOTS-1:0] slot_mask_o,
  output logic [1:0]           st_o,
  output logic [1:0]           pi_o,
  output logic [1:0]           ai_o,
  output logic                 bus_we_o,
  output logic [3:0]           bus_mode_o,
  output hpc_err_t             err_o
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [7:0]       code;
  logic [7:0]       tgt;
  logic             tgt_ok;
  logic [IDX_W-1:0] tgt_idx;
  logic             pwr_req;

  assign code    = word_i[7:0];
  assign tgt     = word_i[15:8];
  assign tgt_ok  = 32'(tgt) < NUM_SLOTS;
  assign tgt_idx = tgt[IDX_W-1:0];
  assign pwr_req = (code[1:0] == 2'd1) || (code[1:0] == 2'd2);

  always_comb begin
    slot_mask_o = '0;
    st_o        = FLD_KEEP;
    pi_o        = FLD_KEEP;
    ai_o        = FLD_KEEP;
    bus_we_o    = 1'b0;
    bus_mode_o  = 4'd0;
    err_o       = '0;
    if (code[7:6] == 2'b00) begin
      if (!tgt_ok) err_o.bad_cmd = 1'b1;
      else if (pwr_req && latch_open_i[tgt_idx]) err_o.sw_open = 1'b1;
      else begin
        slot_mask_o[tgt_idx] = 1'b1;
        st_o = code[1:0];
        pi_o = code[3:2];
        ai_o = code[5:4];
      end
    end else if (code >= 8'h40 && code <= 8'h44) begin
      bus_we_o   = 1'b1;
      bus_mode_o = {1'b0, code[2:0]};
    end else if (code >= 8'h45 && code <= 8'h47) begin
      err_o.bad_mode = 1'b1;
    end else if (code == 8'h48 || code == 8'h49) begin
      if (|latch_open_i) err_o.sw_open = 1'b1;
      else begin
        slot_mask_o = '1;
        st_o = code[0] ? 2'd2 : 2'd1;
      end
    end else if (code[7:4] == 4'h5) begin
      if (lvl2_i && code[3:0] <= MODE_MAX) begin
        bus_we_o   = 1'b1;
        bus_mode_o = code[3:0];
      end else err_o.bad_mode = 1'b1;
    end else begin
      err_o.bad_cmd = 1'b1;
    end
  end
endmodule

// File: rtl/hpc_busy_timer.sv
module hpc_busy_timer #(
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_start_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
endmodule

// File: rtl/hpc_slot_bank.sv
module hpc_slot_bank
  import hpc_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [NUM_SLOTS-1:0]   mask_i,
  input  logic [1:0]             st_i,
  input  logic [1:0]             pi_i,
  input  logic [1:0]             ai_i,
  output logic [2*NUM_SLOTS-1:0] st_o,
  output logic [2*NUM_SLOTS-1:0] pi_o,
  output logic [2*NUM_SLOTS-1:0] ai_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [1:0] st_q, pi_q, ai_q;
    logic       hit;
    assign hit = we_i && mask_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= FLD_OFF;
        pi_q <= FLD_OFF;
        ai_q <= FLD_OFF;
      end else if (hit) begin
        if (st_i != FLD_KEEP) st_q <= st_i;
        if (pi_i != FLD_KEEP) pi_q <= pi_i;
        if (ai_i != FLD_KEEP) ai_q <= ai_i;
      end
    end

    assign st_o[2*g +: 2] = st_q;
    assign pi_o[2*g +: 2] = pi_q;
    assign ai_o[2*g +: 2] = ai_q;
  end
endmodule

// File: rtl/hpc_cmd_engine.sv
module hpc_cmd_engine
  import hpc_cmd_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int BUSY_CYCLES = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_we_i,
  input  logic [15:0]            cmd_wdata_i,
  input  logic                   prog_lvl2_i,
  input  logic [NUM_SLOTS-1:0]   latch_open_i,
  input  logic                   cc_clr_i,
  output logic [3:0]             status_o,
  output logic                   cc_pending_o,
  output logic [3:0]             bus_mode_o,
  output logic [2*NUM_SLOTS-1:0] slot_state_o,
  output logic [2*NUM_SLOTS-1:0] pwr_ind_o,
  output logic [2*NUM_SLOTS-1:0] attn_ind_o
);
  logic [NUM_SLOTS-1:0] mask;
  logic [1:0]           st, pi, ai;
  logic                 bus_we;
  logic [3:0]           bus_val;
  hpc_err_t             dec_err, err_q;
  logic                 busy, done, accept, cc_q;
  logic [3:0]           mode_q;

  assign accept = cmd_we_i && !busy;

  hpc_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .word_i(cmd_wdata_i), .lvl2_i(prog_lvl2_i), .latch_open_i(latch_open_i),
    .slot_mask_o(mask), .st_o(st), .pi_o(pi), .ai_o(ai),
    .bus_we_o(bus_we), .bus_mode_o(bus_val), .err_o(dec_err)
  );

  hpc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept),
    .busy_o(busy), .done_o(done)
  );

  hpc_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(accept), .mask_i(mask),
    .st_i(st), .pi_i(pi), .ai_i(ai),
    .st_o(slot_state_o), .pi_o(pwr_ind_o), .ai_o(attn_ind_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      mode_q <= 4'd0;
      cc_q   <= 1'b0;
    end else begin
      if (accept) err_q <= dec_err;
      if (accept && bus_we) mode_q <= bus_val;
      if (done) cc_q <= 1'b1;          // set beats clear
      else if (cc_clr_i) cc_q <= 1'b0;
    end
  end

  assign status_o     = {err_q, busy};
  assign cc_pending_o = cc_q;
  assign bus_mode_o   = mode_q;

  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && status_o[0]) |=> ($stable(slot_state_o) && $stable(pwr_ind_o)
      && $stable(attn_ind_o) && $stable(bus_mode_o) && $stable(status_o[3:1])));
  p_err_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o[3:1]));
  p_sw_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_err.sw_open) |=> ($stable(slot_state_o) && status_o[1]));
  p_cc_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[0]) |-> cc_pending_o);
  p_mode_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_mode_o <= MODE_MAX);
endmodule

// File: tb/hpc_cmd_engine_tb.sv
module hpc_cmd_engine_tb;
  localparam int PERIOD = 10;
  localparam int NS     = 4;
  localparam int BUSY   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_we = 1'b0;
  logic [15:0]   cmd_wdata = '0;
  logic          lvl2 = 1'b0;
  logic [NS-1:0] latch = '0;
  logic          cc_clr = 1'b0;
  logic [3:0]    status;
  logic          cc;
  logic [3:0]    mode;
  logic [2*NS-1:0] st_o, pi_o, ai_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [1:0] e_st [NS];
  logic [1:0] e_pi [NS];
  logic [1:0] e_ai [NS];
  logic [3:0] e_mode;
  logic [2:0] e_err; // {mode, cmd, switch}

  always #(PERIOD/2) clk = ~clk;

  hpc_cmd_engine #(.NUM_SLOTS(NS), .BUSY_CYCLES(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .prog_lvl2_i(lvl2), .latch_open_i(latch), .cc_clr_i(cc_clr),
    .status_o(status), .cc_pending_o(cc), .bus_mode_o(mode),
    .slot_state_o(st_o), .pwr_ind_o(pi_o), .attn_ind_o(ai_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [15:0] w);
    logic [7:0] c = w[7:0];
    if (c[7:6] == 2'b00) return (32'(w[15:8]) >= NS) ? "R3" : "R2/R4";
    if (c >= 8'h40 && c <= 8'h47) return "R6";
    if (c == 8'h48 || c == 8'h49) return "R5";
    if (c[7:4] == 4'h5) return "R7";
    return "R8";
  endfunction

  task automatic model(input logic [15:0] w);
    logic [7:0] c = w[7:0];
    int t = int'(w[15:8]);
    e_err = 3'b000;
    if (c[7:6] == 2'b00) begin
      if (t >= NS) e_err = 3'b010;
      else if ((c[1:0] == 2'd1 || c[1:0] == 2'd2) && latch[t]) e_err = 3'b001;
      else begin
        if (c[1:0] != 0) e_st[t] = c[1:0];
        if (c[3:2] != 0) e_pi[t] = c[3:2];
        if (c[5:4] != 0) e_ai[t] = c[5:4];
      end
    end else if (c >= 8'h40 && c <= 8'h44) e_mode = 4'(c - 8'h40);
    else if (c >= 8'h45 && c <= 8'h47) e_err = 3'b100;
    else if (c == 8'h48 || c == 8'h49) begin
      if (|latch) e_err = 3'b001;
      else for (int i = 0; i < NS; i++) e_st[i] = (c == 8'h49) ? 2'd2 : 2'd1;
    end else if (c[7:4] == 4'h5) begin
      if (lvl2 && c[3:0] <= 4'd13) e_mode = c[3:0];
      else e_err = 3'b100;
    end else e_err = 3'b010;
  endtask

  task automatic check_state(input string req);
    check({req, " status"}, 32'(status), 32'({e_err, 1'b0}));
    check({req, " mode"}, 32'(mode), 32'(e_mode));
    for (int i = 0; i < NS; i++) begin
      check({req, " slot"}, 32'(st_o[2*i +: 2]), 32'(e_st[i]));
      check({req, " pwr ind"}, 32'(pi_o[2*i +: 2]), 32'(e_pi[i]));
      check({req, " attn ind"}, 32'(ai_o[2*i +: 2]), 32'(e_ai[i]));
    end
  endtask

  task automatic finish_cmd(input string req);
    repeat (BUSY - 1) @(negedge clk);
    check("R9 busy last cycle", 32'(status[0]), 32'd1);
    @(negedge clk);
    check("R9 busy dropped", 32'(status[0]), 32'd0);
    check("R11 complete set", 32'(cc), 32'd1);
    check_state(req);
    cc_clr = 1'b1;
    @(negedge clk);
    cc_clr = 1'b0;
    check("R11 complete cleared", 32'(cc), 32'd0);
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
    model(w);
    check("R9 busy first cycle", 32'(status[0]), 32'd1);
    finish_cmd(req_of(w));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd4242));
    for (int i = 0; i < NS; i++) begin
      e_st[i] = 2'd3; e_pi[i] = 2'd3; e_ai[i] = 2'd3;
    end
    e_mode = 4'd0;
    e_err = 3'b000;
    #(PERIOD * 3);
    @(negedge clk);
    check("R1 complete", 32'(cc), 32'd0);
    check_state("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    issue(16'h013A);            // R2 enable, blink, off on slot 1
    issue(16'h0100);            // R2 all fields keep
    issue(16'h0110);            // R2 attention only
    issue(16'h0401);            // R3 out of range
    latch = 4'b0100;
    issue(16'h0206);            // R4 power on open latch
    issue(16'h0203);            // R4 disable allowed with latch open
    issue(16'h0048);            // R5 rejected, one latch open
    latch = '0;
    issue(16'h0049);            // R5 enable all
    issue(16'h0343);            // R6 set A 100
    issue(16'h0045);            // R6 reserved
    lvl2 = 1'b0;
    issue(16'h005C);            // R7 level 1 rejects set B
    lvl2 = 1'b1;
    issue(16'h005C);            // R7 level 2 accepts
    issue(16'h005E);            // R7 reserved
    issue(16'h004A);            // R8
    issue(16'h00A1);            // R8
    issue(16'h0000);            // R10 error flags replaced

    // R9: second write during busy is ignored
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = 16'h0041;
    @(negedge clk);
    model(16'h0041);
    cmd_wdata = 16'h0044;       // still asserted while busy
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (BUSY - 2) @(negedge clk);
    check("R9 busy last cycle", 32'(status[0]), 32'd1);
    @(negedge clk);
    check("R9 busy dropped", 32'(status[0]), 32'd0);
    check("R9 ignored write mode", 32'(mode), 32'd1);
    cc_clr = 1'b1;
    @(negedge clk);
    cc_clr = 1'b0;

    for (int n = 0; n < 150; n++) begin
      int k = int'($urandom % 8);
      logic [7:0] c;
      logic [7:0] s = 8'($urandom % (NS + 2));
      case (k)
        3: c = 8'h40 + 8'($urandom % 8);
        4: c = 8'h48 + 8'($urandom % 2);
        5: c = 8'h50 + 8'($urandom % 16);
        6: c = 8'($urandom);
        default: c = {2'b00, 6'($urandom)};
      endcase
      latch = (($urandom % 3) == 0) ? NS'($urandom) : '0;
      lvl2 = 1'($urandom);
      w = {s, c};
      issue(w);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule